// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks through the column addresses of one SDRAM burst. A start strobe loads a starting column together with a burst-length code and a wrap-order bit. From the next cycle on, the block presents one column address per clock, with a valid flag and a flag that marks the final beat. It stops when the programmed length is used up or when a stop request arrives.

Fixed lengths of 1, 2, 4 and 8 wrap inside an aligned window. The wrap order is either sequential (count up and wrap) or interleaved (XOR of the start offset with the beat index). A full-page setting counts through all 1024 columns and keeps going until it is stopped. A new start is accepted on any cycle, and it replaces whatever burst is in progress. A low clock enable holds every output from the following cycle.

Top module: `sdr_burst_colgen`

## Requirements
- R1: After reset, `col_vld` and `col_last` are 0.
- R2: When `start` is high at a rising edge with `cke` high, the next cycle shows `col_vld`=1 and `col`=`start_col`. This holds even while a burst is in progress, which is then abandoned.
- R3: `blen_code` is sampled with `start`. The codes are 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats and 7 = full page. Codes 4 to 6 act as 1 beat. A fixed-length burst keeps `col_vld` high for exactly that many cycles of high `cke`.
- R4: With `ilv_sel`=0 and a fixed length L, beat k shows the start column with its low log2(L) bits replaced by (start low bits + k) mod L. The upper bits are unchanged.
- R5: With `ilv_sel`=1 and a fixed length L, beat k shows the start column with its low log2(L) bits replaced by (start low bits XOR k).
- R6: A full-page burst shows (start + k) mod 1024 on beat k and never ends by itself. `ilv_sel` has no effect on a full-page burst.
- R7: `col_last` is high exactly on the final beat of a fixed-length burst. It is never high during a full-page burst.
- R8: `stop` high at an edge with `cke` high and `start` low ends the burst, so `col_vld` is 0 in the next cycle. When `start` and `stop` are both high, `start` wins.
- R9: When `cke` is low at an edge, `col`, `col_vld` and `col_last` hold their values in the next cycle, and `start` and `stop` are ignored.
- R10: Changes to `blen_code` and `ilv_sel` while a burst runs do not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the sequence |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 10 | Starting column |
| blen_code | input | 3 | Burst length code |
| ilv_sel | input | 1 | 1 = interleaved order, 0 = sequential |
| stop | input | 1 | End the current burst |
| col | output | 10 | Current column address |
| col_vld | output | 1 | `col` holds a burst beat |
| col_last | output | 1 | Current beat is the final one |

## Verification
A corrupted beat counter or a wrong latched mode shows up in the very next `col` value, because the address is formed combinationally from the registered start column and the counter. A broken window mask shows up as a wrong upper bit at the first wrap, which comes after at most 8 beats for fixed lengths and 2 beats in the wrap tests. A wrong terminal count shows as `col_last` on the wrong beat, or as `col_vld` ending a cycle early or late. The bench compares every cycle's valid flag, address and last flag against a model, so any difference is reported on the cycle it first appears.

// File: rtl/sdr_colgen_pkg.sv
package sdr_colgen_pkg;

   typedef struct packed {
      logic       page;
      logic       ilv;
      logic [1:0] lg;
   } burst_mode_t;

   function automatic burst_mode_t decode_mode(input logic [2:0] code, input logic ilv_in);
      burst_mode_t m;
      m.page = 1'b0;
      m.lg   = 2'd0;
      case (code)
         3'd1:    m.lg = 2'd1;
         3'd2:    m.lg = 2'd2;
         3'd3:    m.lg = 2'd3;
         3'd7:    m.page = 1'b1;
         default: m.lg = 2'd0;
      endcase
      m.ilv = ilv_in & ~m.page;
      return m;
   endfunction

endpackage

// File: rtl/sdr_colgen_mask.sv
module sdr_colgen_mask #(
   parameter int COL_W = 10
) (
   input  logic [1:0]       lg,
   input  logic             page,
   output logic [COL_W-1:0] mask
);
   localparam int FIX_BITS = 3;

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      if (i < FIX_BITS) begin : g_fix
         assign mask[i] = page | (lg > 2'(i));
      end else begin : g_up
         assign mask[i] = page;
      end
   end
endmodule

// File: rtl/sdr_colgen_ctrl.sv
module sdr_colgen_ctrl
   import sdr_colgen_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  burst_mode_t      mode_in,
   input  logic             stop,
   input  logic [COL_W-1:0] mask,
   output logic             vld,
   output logic [COL_W-1:0] cnt,
   output logic [COL_W-1:0] anchor,
   output burst_mode_t      mode_q,
   output logic             last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld    <= 1'b0;
         cnt    <= '0;
         anchor <= '0;
         mode_q <= '0;
      end else if (cke) begin
         if (start) begin
            vld    <= 1'b1;
            cnt    <= '0;
            anchor <= start_col;
            mode_q <= mode_in;
         end else if (vld) begin
            if (stop || last) vld <= 1'b0;
            else              cnt <= cnt + 1'b1;
         end
      end
   end

   assign last = vld && !mode_q.page && (cnt == mask);

   // R8
   stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke && stop && !start |=> !vld);
   // R7
   last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke && last && !start |=> !vld);
   // R9
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> $stable(vld) && $stable(cnt) && $stable(anchor));
endmodule

// File: rtl/sdr_colgen_addr.sv
module sdr_colgen_addr #(
   parameter int COL_W = 10
) (
   input  logic [COL_W-1:0] anchor,
   input  logic [COL_W-1:0] cnt,
   input  logic [COL_W-1:0] mask,
   input  logic             ilv,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] stepped;

   always_comb begin
      stepped = ilv ? (anchor ^ cnt) : (anchor + cnt);
      col     = (anchor & ~mask) | (stepped & mask);
   end
endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
   import sdr_colgen_pkg::*;
#(
   parameter int COL_W  = 10,
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              start,
   input  logic [COL_W-1:0]  start_col,
   input  logic [CODE_W-1:0] blen_code,
   input  logic              ilv_sel,
   input  logic              stop,
   output logic [COL_W-1:0]  col,
   output logic              col_vld,
   output logic              col_last
);
   if (COL_W < 3) begin : g_bad_col
      $fatal(1, "COL_W must cover an 8-beat window");
   end
   if (CODE_W != 3) begin : g_bad_code
      $fatal(1, "CODE_W must be 3");
   end

   burst_mode_t      mode_in, mode_q;
   logic [COL_W-1:0] mask, cnt, anchor;

   assign mode_in = decode_mode(blen_code, ilv_sel);

   sdr_colgen_mask #(.COL_W(COL_W)) u_mask (
      .lg(mode_q.lg), .page(mode_q.page), .mask(mask)
   );

   sdr_colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cke(cke), .start(start),
      .start_col(start_col), .mode_in(mode_in), .stop(stop), .mask(mask),
      .vld(col_vld), .cnt(cnt), .anchor(anchor), .mode_q(mode_q),
      .last(col_last)
   );

   sdr_colgen_addr #(.COL_W(COL_W)) u_addr (
      .anchor(anchor), .cnt(cnt), .mask(mask), .ilv(mode_q.ilv), .col(col)
   );

   // R2
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke && start |=> col_vld && (col == $past(start_col)));
   // R3
   no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke && col_vld && !col_last && !start && !stop |=> col_vld);
endmodule

// File: tb/sim_sdr_burst_colgen.sv
`timescale 1ns/1ps
module sim_sdr_burst_colgen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b1, start = 1'b0, ilv_sel = 1'b0, stop = 1'b0;
   logic [9:0] start_col = '0;
   logic [2:0] blen_code = '0;
   logic [9:0] col;
   logic       col_vld, col_last;

   int n_chk = 0, n_fail = 0;

   typedef struct {
      bit         v;
      logic [9:0] c;
      bit         l;
      string      tag;
   } exp_t;
   exp_t q[$];

   // reference state
   bit m_vld = 0;
   int m_anchor = 0, m_k = 0, m_len = 1;
   bit m_ilv = 0;

   always #2.5 clk = ~clk;

   sdr_burst_colgen u0 (
      .clk(clk), .rst_n(rst_n), .cke(cke), .start(start), .start_col(start_col),
      .blen_code(blen_code), .ilv_sel(ilv_sel), .stop(stop),
      .col(col), .col_vld(col_vld), .col_last(col_last)
   );

   function automatic int len_of(input int code);
      case (code)
         0: return 1;
         1: return 2;
         2: return 4;
         3: return 8;
         7: return 0;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_col();
      int off, base;
      if (m_len == 0) return (m_anchor + m_k) % 1024;
      off  = m_anchor % m_len;
      base = m_anchor - off;
      if (m_ilv) return base + (off ^ m_k);
      return base + ((off + m_k) % m_len);
   endfunction

   task automatic step(input bit s, input int sc, input int code, input bit bt,
                       input bit sp, input bit ck, input string tag);
      exp_t e;
      start = s; start_col = 10'(sc); blen_code = 3'(code);
      ilv_sel = bt; stop = sp; cke = ck;
      @(posedge clk);
      if (ck) begin
         if (s) begin
            m_vld = 1; m_anchor = sc; m_k = 0; m_len = len_of(code);
            m_ilv = bt && (m_len != 0);
         end else if (m_vld) begin
            if (sp || (m_len != 0 && m_k == m_len - 1)) m_vld = 0;
            else m_k = (m_k + 1) % 1024;
         end
      end
      #1;
      e.v = m_vld;
      e.c = m_vld ? 10'(exp_col()) : '0;
      e.l = m_vld && (m_len != 0) && (m_k == m_len - 1);
      e.tag = tag;
      q.push_back(e);
      @(negedge clk);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 5, 1, 0, 1, tag);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if (e.v) begin
            if (!(col_vld === 1'b1 && col === e.c && col_last === e.l)) begin
               n_fail++;
               $display("FAIL %s: vld=%b col=%h last=%b expected vld=1 col=%h last=%b",
                        e.tag, col_vld, col, col_last, e.c, e.l);
            end
         end else if (!(col_vld === 1'b0 && col_last === 1'b0)) begin
            n_fail++;
            $display("FAIL %s: vld=%b last=%b expected vld=0 last=0",
                     e.tag, col_vld, col_last);
         end
      end
   end

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      n_chk++;
      if (!(col_vld === 1'b0 && col_last === 1'b0)) begin
         n_fail++;
         $display("FAIL R1: vld=%b last=%b expected 0 0", col_vld, col_last);
      end
      rst_n = 1'b1;
      @(negedge clk);
      // R4 sequential BL4, wrap inside window
      step(1, 'h0F6, 2, 0, 0, 1, "R4");
      idle(4, "R4");
      // R5 interleaved BL8
      step(1, 'h3FD, 3, 1, 0, 1, "R5");
      idle(8, "R5");
      // R3 BL2, BL1 and reserved code 5 as one beat
      step(1, 'h201, 1, 0, 0, 1, "R3");
      idle(2, "R3");
      step(1, 'h155, 0, 0, 0, 1, "R3");
      step(1, 'h0AA, 5, 1, 0, 1, "R3");
      idle(2, "R3");
      // R6 full page with interleave selected, wraps past 1023, then R8 stop
      step(1, 'h3FE, 7, 1, 0, 1, "R6");
      idle(6, "R6");
      step(0, 0, 0, 0, 1, 1, "R8");
      idle(2, "R8");
      // R2 abort: new start mid-burst
      step(1, 'h010, 3, 0, 0, 1, "R2");
      idle(2, "R2");
      step(1, 'h123, 2, 1, 0, 1, "R2");
      idle(4, "R2");
      // R9 freeze with start and stop ignored while cke is low
      step(1, 'h08C, 3, 0, 0, 1, "R9");
      idle(2, "R9");
      step(1, 'h300, 0, 0, 0, 0, "R9");
      step(0, 0, 0, 0, 1, 0, "R9");
      step(0, 0, 0, 0, 0, 0, "R9");
      idle(7, "R9");
      // R10 mode inputs changing mid-burst
      step(1, 'h045, 2, 0, 0, 1, "R10");
      step(0, 0, 7, 1, 0, 1, "R10");
      step(0, 0, 0, 1, 0, 1, "R10");
      step(0, 0, 3, 0, 0, 1, "R10");
      idle(2, "R10");
      // R8 start and stop together: start wins; stop on BL1
      step(1, 'h2F0, 1, 0, 1, 1, "R8");
      idle(2, "R8");
      step(1, 'h111, 0, 0, 0, 1, "R8");
      step(0, 0, 0, 0, 1, 1, "R8");
      // R7 last flag on BL8 sequential and full page without last
      step(1, 'h3F9, 3, 0, 0, 1, "R7");
      idle(8, "R7");
      step(1, 'h000, 7, 0, 0, 1, "R7");
      idle(9, "R7");
      step(0, 0, 0, 0, 1, 1, "R7");
      idle(1, "R7");
      @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule